// File: doc/BRIEF.md
# Memory-Mapped Network Packet Launcher

This block assembles an outgoing network packet from register stores issued by a local processor and streams it onto a word-wide output channel with valid/ready handshaking. Software fills in a destination, an opcode, a count of explicit operand words and the operand values themselves, plus a memory start address and a word count for a data section. A single store to the launch address then commits the packet. The packet leaves as one header word, then the operands in slot order, then the data words. The block reads the data words itself through a synchronous memory read port with one cycle of latency.

The header word packs the node's own identifier, the total word count after the header, and the opcode. The destination does not appear in the packet words. It travels on a sideband that is held for the whole packet. An opcode whose top bit is set marks a software-defined interrupt-class message, and a clear top bit marks a coherence protocol message. The block passes the opcode through unchanged in both cases. While a packet is in flight the register port stalls every store, the launch store included. A second launch therefore waits for the first packet to finish and is never dropped.

Top module: `pkt_launcher`

## Requirements
- R1: After reset `tx_valid_o`, `busy_o`, `err_o` and `mem_re_o` are low and `wr_ready_o` is high.
- R2: The header word is {node_id_i[7:0] in bits 31:24, length in bits 23:16, opcode in bits 15:0}. The length is the operand count plus the data word count. The opcode is copied verbatim, including bit 15, which is the interrupt-class marker.
- R3: A packet is the header, then operand slots 0 to n-1, then the data words in address order. `tx_last_o` is high only on the final word of the packet.
- R4: Register word addresses are: destination 0, opcode 1, data start address 2, data word count 3, operand count 4, launch 5, operand slot k at 8+k. An operand count store above 8 stores 8 and sets `err_o`. A store of 8 or less stores the value and clears `err_o`.
- R5: A store to address 5 starts a packet. `busy_o` is high from the next cycle until the cycle after the last word is accepted.
- R6: While busy, `wr_ready_o` is low and stores stall. A launch store held during a packet is accepted once the packet ends and produces a second identical packet.
- R7: `tx_dest_o` carries bits 7:0 of the destination register and is stable on every word of the packet. It adds nothing to the header length.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, the values of `tx_data_o`, `tx_last_o` and `tx_dest_o` are held and `tx_valid_o` stays high.
- R9: The data word count takes bits 6:0 of the stored value. Zero operands, zero data words, or both are legal. A header-only packet raises `tx_last_o` on the header.
- R10: Each data word costs exactly one read pulse on `mem_re_o` at address start+j, taken modulo 2^16. The word is captured from `mem_rdata_i` the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 8 | Identifier of this node, placed in the header |
| wr_en_i | input | 1 | Register store request |
| wr_addr_i | input | 4 | Register word address |
| wr_data_i | input | 32 | Register store data |
| wr_ready_o | output | 1 | Store accepted this cycle when high |
| busy_o | output | 1 | Packet in flight |
| err_o | output | 1 | Last operand count store was out of range |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory word address |
| mem_rdata_i | input | 32 | Memory read data, one cycle after the strobe |
| tx_valid_o | output | 1 | Output word valid |
| tx_ready_i | input | 1 | Output word accepted |
| tx_data_o | output | 32 | Output word |
| tx_dest_o | output | 8 | Destination sideband |
| tx_last_o | output | 1 | Final word of the packet |

## Verification
The bench sweeps every operand count from 0 to 8 against several data lengths, under both free-flowing and irregular backpressure. This exposes a design that drops the header-only case, misplaces `tx_last_o` when one section is empty, or slips an operand slot. A data start near the top of the address space checks that the fetch address wraps rather than carries, and the read pulses are counted so a design that fetches a word twice or fetches ahead is caught. Out-of-range operand counts check for saturation rather than truncation: a truncating design would send a count of 1 for a store of 9 and a wrong header length. A launch store issued mid-packet must stall and then yield a second copy, so a design that loses or corrupts a pending launch fails.

// File: rtl/plr_pkg.sv
package plr_pkg;
  localparam int ID_W   = 8;
  localparam int LEN_W  = 8;
  localparam int OPC_W  = 16;
  localparam int WORD_W = 32;
  localparam int REG_AW = 4;

  localparam logic [REG_AW-1:0] RA_DEST  = 4'd0;
  localparam logic [REG_AW-1:0] RA_OPC   = 4'd1;
  localparam logic [REG_AW-1:0] RA_BASE  = 4'd2;
  localparam logic [REG_AW-1:0] RA_DLEN  = 4'd3;
  localparam logic [REG_AW-1:0] RA_OPCNT = 4'd4;
  localparam logic [REG_AW-1:0] RA_TRIG  = 4'd5;
  localparam int                RA_OPND  = 8;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_OPS, S_DREQ, S_DWAIT, S_DSEND} seq_st_e;
  typedef enum logic [1:0] {SEL_HDR, SEL_OPND, SEL_DATA} out_sel_e;

  function automatic logic [WORD_W-1:0] pack_hdr(logic [ID_W-1:0] src, logic [LEN_W-1:0] len,
                                                 logic [OPC_W-1:0] opc);
    return {src, len, opc};
  endfunction
endpackage

// File: rtl/plr_regs.sv
module plr_regs
  import plr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_OPS = 8,
  parameter int DLEN_W  = 7,
  localparam int OPS_W  = $clog2(MAX_OPS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [REG_AW-1:0]     wr_addr_i,
  input  logic [WORD_W-1:0]     wr_data_i,
  input  logic                  wr_ok_i,
  output logic [ID_W-1:0]       dest_o,
  output logic [OPC_W-1:0]      opc_o,
  output logic [ADDR_W-1:0]     base_o,
  output logic [DLEN_W-1:0]     dlen_o,
  output logic [OPS_W-1:0]      opcnt_o,
  output logic [WORD_W-1:0]     opnd_o [MAX_OPS],
  output logic                  err_o,
  output logic                  trig_o
);
  logic wr_acc;
  assign wr_acc = wr_en_i && wr_ok_i;
  assign trig_o = wr_acc && (wr_addr_i == RA_TRIG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_o  <= '0;
      opc_o   <= '0;
      base_o  <= '0;
      dlen_o  <= '0;
      opcnt_o <= '0;
      err_o   <= 1'b0;
    end else if (wr_acc) begin
      case (wr_addr_i)
        RA_DEST: dest_o <= wr_data_i[ID_W-1:0];
        RA_OPC:  opc_o  <= wr_data_i[OPC_W-1:0];
        RA_BASE: base_o <= wr_data_i[ADDR_W-1:0];
        RA_DLEN: dlen_o <= wr_data_i[DLEN_W-1:0];
        RA_OPCNT: begin
          if (wr_data_i > WORD_W'(MAX_OPS)) begin
            opcnt_o <= OPS_W'(MAX_OPS);
            err_o   <= 1'b1;
          end else begin
            opcnt_o <= wr_data_i[OPS_W-1:0];
            err_o   <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < MAX_OPS; k++) begin : g_slot
    localparam logic [REG_AW-1:0] SLOT_A = REG_AW'(RA_OPND + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           opnd_o[k] <= '0;
      else if (wr_acc && wr_addr_i == SLOT_A) opnd_o[k] <= wr_data_i;
    end
  end
endmodule

// File: rtl/plr_seq.sv
module plr_seq
  import plr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_OPS = 8,
  parameter int DLEN_W  = 7,
  localparam int OPS_W  = $clog2(MAX_OPS + 1),
  localparam int IDX_W  = (OPS_W > DLEN_W) ? OPS_W : DLEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [OPS_W-1:0]  opcnt_i,
  input  logic [DLEN_W-1:0] dlen_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              tx_ready_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              wr_ok_o,
  output out_sel_e          sel_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [WORD_W-1:0] hold_o,
  output logic              tx_valid_o,
  output logic              tx_last_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] hold_q;
  logic [IDX_W-1:0]  ops_x, dl_x, idx_nx;
  logic              ops_end, dat_end, fire;

  assign ops_x   = IDX_W'(opcnt_i);
  assign dl_x    = IDX_W'(dlen_i);
  assign idx_nx  = idx_q + IDX_W'(1);
  assign ops_end = (idx_nx == ops_x);
  assign dat_end = (idx_nx == dl_x);

  always_comb begin
    tx_valid_o = (st_q == S_HDR) || (st_q == S_OPS) || (st_q == S_DSEND);
    fire       = tx_valid_o && tx_ready_i;
    tx_last_o  = ((st_q == S_HDR) && ops_x == '0 && dl_x == '0)
              || ((st_q == S_OPS) && ops_end && dl_x == '0)
              || ((st_q == S_DSEND) && dat_end);
    // next fetch overlaps the accept of the current word
    mem_re_o   = (st_q == S_DREQ) || ((st_q == S_DSEND) && fire && !dat_end);
    mem_addr_o = base_i + ADDR_W'((st_q == S_DREQ) ? idx_q : idx_nx);
    case (st_q)
      S_HDR:   sel_o = SEL_HDR;
      S_OPS:   sel_o = SEL_OPND;
      default: sel_o = SEL_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      hold_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (trig_i) begin
          st_q  <= S_HDR;
          idx_q <= '0;
        end
        S_HDR: if (fire) begin
          idx_q <= '0;
          if (ops_x != '0)     st_q <= S_OPS;
          else if (dl_x != '0) st_q <= S_DREQ;
          else                 st_q <= S_IDLE;
        end
        S_OPS: if (fire) begin
          if (ops_end) begin
            idx_q <= '0;
            st_q  <= (dl_x != '0) ? S_DREQ : S_IDLE;
          end else begin
            idx_q <= idx_nx;
          end
        end
        S_DREQ: st_q <= S_DWAIT;
        S_DWAIT: begin
          hold_q <= mem_rdata_i;
          st_q   <= S_DSEND;
        end
        S_DSEND: if (fire) begin
          if (dat_end) st_q <= S_IDLE;
          else begin
            idx_q <= idx_nx;
            st_q  <= S_DWAIT;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != S_IDLE);
  assign wr_ok_o = (st_q == S_IDLE);
  assign idx_o   = idx_q;
  assign hold_o  = hold_q;
endmodule

// File: rtl/plr_out.sv
module plr_out
  import plr_pkg::*;
#(
  parameter int MAX_OPS = 8,
  parameter int DLEN_W  = 7,
  localparam int OPS_W  = $clog2(MAX_OPS + 1),
  localparam int IDX_W  = (OPS_W > DLEN_W) ? OPS_W : DLEN_W
) (
  input  out_sel_e          sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ID_W-1:0]   src_i,
  input  logic [OPS_W-1:0]  opcnt_i,
  input  logic [DLEN_W-1:0] dlen_i,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [WORD_W-1:0] opnd_i [MAX_OPS],
  input  logic [WORD_W-1:0] hold_i,
  output logic [WORD_W-1:0] data_o
);
  logic [LEN_W-1:0]  len;
  logic [WORD_W-1:0] opnd_sel;

  assign len = LEN_W'(opcnt_i) + LEN_W'(dlen_i);

  always_comb begin
    opnd_sel = '0;
    for (int k = 0; k < MAX_OPS; k++)
      if (idx_i == IDX_W'(k)) opnd_sel = opnd_i[k];
  end

  always_comb begin
    case (sel_i)
      SEL_HDR:  data_o = pack_hdr(src_i, len, opc_i);
      SEL_OPND: data_o = opnd_sel;
      default:  data_o = hold_i;
    endcase
  end
endmodule

// File: rtl/pkt_launcher.sv
module pkt_launcher
  import plr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MAX_OPS = 8,
  parameter int DLEN_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        node_id_i,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              wr_ready_o,
  output logic              busy_o,
  output logic              err_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [31:0]       tx_data_o,
  output logic [7:0]        tx_dest_o,
  output logic              tx_last_o
);
  localparam int OPS_W = $clog2(MAX_OPS + 1);
  localparam int IDX_W = (OPS_W > DLEN_W) ? OPS_W : DLEN_W;

  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] base;
  logic [DLEN_W-1:0] dlen;
  logic [OPS_W-1:0]  opcnt;
  logic [WORD_W-1:0] opnd [MAX_OPS];
  logic [WORD_W-1:0] hold;
  logic [IDX_W-1:0]  idx;
  logic              trig;
  out_sel_e          sel;

  plr_regs #(.ADDR_W(ADDR_W), .MAX_OPS(MAX_OPS), .DLEN_W(DLEN_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .wr_ok_i (wr_ready_o),
    .dest_o  (tx_dest_o),
    .opc_o   (opc),
    .base_o  (base),
    .dlen_o  (dlen),
    .opcnt_o (opcnt),
    .opnd_o  (opnd),
    .err_o,
    .trig_o  (trig)
  );

  plr_seq #(.ADDR_W(ADDR_W), .MAX_OPS(MAX_OPS), .DLEN_W(DLEN_W)) u_seq (
    .clk_i, .rst_ni,
    .trig_i  (trig),
    .opcnt_i (opcnt),
    .dlen_i  (dlen),
    .base_i  (base),
    .tx_ready_i, .mem_rdata_i,
    .busy_o,
    .wr_ok_o (wr_ready_o),
    .sel_o   (sel),
    .idx_o   (idx),
    .hold_o  (hold),
    .tx_valid_o, .tx_last_o, .mem_re_o, .mem_addr_o
  );

  plr_out #(.MAX_OPS(MAX_OPS), .DLEN_W(DLEN_W)) u_out (
    .sel_i   (sel),
    .idx_i   (idx),
    .src_i   (node_id_i),
    .opcnt_i (opcnt),
    .dlen_i  (dlen),
    .opc_i   (opc),
    .opnd_i  (opnd),
    .hold_i  (hold),
    .data_o  (tx_data_o)
  );
endmodule

// File: rtl/plr_chk.sv
module plr_chk #(
  parameter int MAX_OPS = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [3:0]  wr_addr_i,
  input logic [31:0] wr_data_i,
  input logic        wr_ready_o,
  input logic        busy_o,
  input logic        err_o,
  input logic        mem_re_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i,
  input logic [31:0] tx_data_o,
  input logic [7:0]  tx_dest_o,
  input logic        tx_last_o
);
  localparam logic [3:0] A_OPCNT = 4'd4;
  localparam logic [3:0] A_TRIG  = 4'd5;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)
                                  && $stable(tx_dest_o));

  assert_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_ready_o && wr_addr_i == A_TRIG |=> busy_o);

  assert_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_last_o |=> !busy_o);

  assert_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_en_i && wr_addr_i == A_TRIG));

  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !wr_ready_o);

  assert_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_ready_o && wr_addr_i == A_OPCNT && wr_data_i > 32'(MAX_OPS) |=> err_o);

  assert_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_ready_o && wr_addr_i == A_OPCNT && wr_data_i <= 32'(MAX_OPS) |=> !err_o);

  assert_fetch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> busy_o && (!tx_valid_o || tx_ready_i));
endmodule

bind pkt_launcher plr_chk #(.MAX_OPS(MAX_OPS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .wr_ready_o (wr_ready_o),
  .busy_o     (busy_o),
  .err_o      (err_o),
  .mem_re_o   (mem_re_o),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_dest_o  (tx_dest_o),
  .tx_last_o  (tx_last_o)
);

// File: tb/sim_pkt_launcher.sv
module sim_pkt_launcher;
  localparam logic [7:0] NODE = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        wr_ready, busy, err, mem_re, tx_valid, tx_last;
  logic        tx_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] tx_data;
  logic [7:0]  tx_dest;

  int n_chk = 0, n_fail = 0, re_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk; // 20 ns period, 50 MHz

  pkt_launcher u0 (
    .clk_i(clk), .rst_ni(rst_n), .node_id_i(NODE),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_ready_o(wr_ready),
    .busy_o(busy), .err_o(err), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_data_o(tx_data), .tx_dest_o(tx_dest), .tx_last_o(tx_last)
  );

  function automatic logic [31:0] memval(logic [15:0] a);
    return ({16'h0, a} * 32'h9E3779B1) + 32'h00005A5A;
  endfunction

  function automatic logic [31:0] opval(int pid, int k);
    return (32'(pid) * 32'h01010101) ^ (32'(k) * 32'h00F10E00) ^ 32'hC0DE0000;
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= memval(mem_addr);
      re_cnt    <= re_cnt + 1;
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog(int pid, logic [31:0] opcnt_raw, int nops, int dlen, logic [15:0] base,
                      logic [15:0] opc, logic [7:0] dest);
    wr(4'd0, {24'hFFFFFF, dest});
    wr(4'd1, {16'hBEEF, opc});
    wr(4'd2, {16'h0, base});
    wr(4'd3, 32'(dlen) | 32'h00000F80); // upper bits beyond 6:0 dropped (R9)
    wr(4'd4, opcnt_raw);
    for (int k = 0; k < nops; k++) wr(4'(8 + k), opval(pid, k));
  endtask

  task automatic rx(int pid, int nops, int dlen, logic [15:0] base, logic [15:0] opc,
                    logic [7:0] dest, int bp);
    int n = 1 + nops + dlen;
    int got = 0;
    int cyc = 0;
    bit stalled = 0;
    logic [31:0] prev = '0;
    logic [31:0] exp;
    while (got < n) begin
      @(negedge clk);
      cyc++;
      if (stalled) check(tx_valid && tx_data == prev, "R8 hold", tx_data, prev);
      tx_ready = (bp == 0) ? 1'b1 : (((cyc * 7 + pid) % 5) > 1);
      if (tx_valid) begin
        if (tx_ready) begin
          if (got == 0) begin
            exp = {NODE, 8'(nops + dlen), opc};
            check(tx_data == exp, "R2 header", tx_data, exp);
          end else if (got <= nops) begin
            exp = opval(pid, got - 1);
            check(tx_data == exp, "R3 operand", tx_data, exp);
          end else begin
            exp = memval(base + 16'(got - 1 - nops));
            check(tx_data == exp, "R10 data", tx_data, exp);
          end
          check(tx_last == (got == n - 1), "R3 last", 32'(tx_last), 32'(got == n - 1));
          check(tx_dest == dest, "R7 dest", 32'(tx_dest), 32'(dest));
          got++;
          stalled = 0;
        end else begin
          stalled = 1;
          prev = tx_data;
        end
      end
      if (cyc > 4000) begin
        check(0, "R3 stream stuck", 32'(got), 32'(n));
        got = n;
      end
    end
    @(negedge clk);
    tx_ready = 1'b0;
    check(!busy, "R5 idle after last", 32'(busy), 0);
  endtask

  task automatic run(int pid, logic [31:0] opcnt_raw, int nops, int dlen, logic [15:0] base,
                     logic [15:0] opc, logic [7:0] dest, int bp);
    int re0;
    prog(pid, opcnt_raw, (nops > 8) ? 8 : nops, dlen, base, opc, dest);
    re0 = re_cnt;
    wr(4'd5, 32'h1);
    check(busy && !wr_ready, "R5 busy after launch", 32'(busy), 1);
    rx(pid, nops, dlen, base, opc, dest, bp);
    check(re_cnt - re0 == dlen, "R10 read count", 32'(re_cnt - re0), 32'(dlen));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int pid = 0;
    int dls[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    check(!tx_valid && !busy && !err && !mem_re && wr_ready, "R1 in reset",
          {27'h0, tx_valid, busy, err, mem_re, wr_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_valid && !busy && !err && !mem_re && wr_ready, "R1 after reset",
          {27'h0, tx_valid, busy, err, mem_re, wr_ready}, 32'h1);

    // sweep operand counts and data lengths (R2 R3 R9 R10)
    for (int o = 0; o <= 8; o++) begin
      for (int d = 0; d < 4; d++) begin
        logic [15:0] opc = 16'(pid * 16'h1357) ^ ((pid % 2) ? 16'h8000 : 16'h0);
        logic [15:0] base = (pid % 3 == 0) ? 16'hFFFE : 16'(pid * 37);
        run(pid, 32'(o), o, dls[d], base, opc, 8'(pid * 11), pid % 2);
        pid++;
      end
    end

    // R4 saturation of operand count
    wr(4'd4, 32'd9);
    @(negedge clk);
    check(err, "R4 err set on 9", 32'(err), 1);
    run(pid, 32'd12, 8, 2, 16'h0100, 16'h8421, 8'h3C, 1);
    check(err, "R4 err sticky", 32'(err), 1);
    pid++;
    wr(4'd4, 32'd3);
    @(negedge clk);
    check(!err, "R4 err cleared", 32'(err), 0);

    // R9 largest data section with full operands: length 135
    run(pid, 32'd8, 8, 127, 16'hFFC0, 16'h7FFF, 8'h01, 0);
    pid++;

    // R6 launch store held during a packet
    prog(pid, 32'd2, 2, 3, 16'h0040, 16'h9001, 8'h77);
    wr(4'd5, 32'h1);
    fork
      rx(pid, 2, 3, 16'h0040, 16'h9001, 8'h77, 1);
      begin
        repeat (3) @(negedge clk);
        check(!wr_ready, "R6 stores stalled while busy", 32'(wr_ready), 0);
        wr(4'd5, 32'h1);
      end
    join
    check(busy, "R6 held launch accepted", 32'(busy), 1);
    rx(pid, 2, 3, 16'h0040, 16'h9001, 8'h77, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule